// File: doc/BRIEF.md
# Two-Section Decade Counter with Preset to Nine

This block is a four-bit counter split into two sections that run independently. A divide-by-two section toggles output bit 0 on each falling edge of its own step input. A divide-by-five section steps output bits 3..1 through 0, 1, 2, 3, 4 and back to 0 on each falling edge of a second step input. Both step inputs are sampled by one system clock. Each passes through a synchronizer and an edge detector before it can change the state.

Two gated controls act on the whole counter. The clear control acts only when both of its inputs are HIGH, and it forces the count to zero. The preset control acts only when both of its inputs are HIGH, and it forces the count to nine (binary 1001). Preset wins over clear. While either control is active, the output shows the forced value in the same cycle, and no counting takes place.

The two sections can be chained outside the block. Feeding bit 0 back into the divide-by-five step input gives a BCD count from 0 to 9. Feeding bit 3 into the divide-by-two step input, with pulses applied to the divide-by-five input, turns bit 0 into a divide-by-ten square wave. The system reset is active-low and synchronous.

Top module: `decade_counter_p9`

## Requirements
- R1: A rising transition on either step input never changes the count.
- R2: Each falling edge on `step_x2` inverts `count_q[0]` and leaves `count_q[3:1]` unchanged.
- R3: Each falling edge on `step_x5` advances `count_q[3:1]` through 0,1,2,3,4 and wraps from 4 to 0. It leaves `count_q[0]` unchanged, and `count_q[3:1]` never exceeds 4.
- R4: When `clr_a` and `clr_b` are both 1 and preset is inactive, `count_q` is 0000. With only one of the two at 1, the count is unaffected.
- R5: When `pre_a` and `pre_b` are both 1, `count_q` is 1001. With only one of the two at 1, the count is unaffected.
- R6: Preset has priority: with all four control inputs at 1, `count_q` is 1001.
- R7: While either gated control is active, falling edges on the step inputs are lost. After the control is released, the count continues from the forced value.
- R8: With `count_q[0]` linked to `step_x5` and pulses applied to `step_x2`, the count after pulse k is k mod 10.
- R9: With `count_q[3]` linked to `step_x2` and pulses applied to `step_x5`, `count_q[0]` is 0 for five pulses and then 1 for five pulses, repeating every ten pulses.
- R10: With the default two synchronizer stages, a falling edge that is set up before rising clock edge e1 changes the count after rising edge e3, and not after e2.
- R11: While `rst_n` is 0 at a rising clock edge, the count becomes 0000 (controls inactive) and the synchronizers clear.
- R12: A gated control changes `count_q` in the same cycle it is asserted, before any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Synchronous active-low system reset |
| step_x2 | input | 1 | Step input of the divide-by-two section, acts on its falling edge |
| step_x5 | input | 1 | Step input of the divide-by-five section, acts on its falling edge |
| clr_a | input | 1 | Clear gate input A |
| clr_b | input | 1 | Clear gate input B |
| pre_a | input | 1 | Preset-to-nine gate input A |
| pre_b | input | 1 | Preset-to-nine gate input B |
| count_q | output | 4 | Counter value; bit 0 from the divide-by-two section, bits 3..1 from the divide-by-five section |

## Verification
Four patterns are used. First, single pulses are applied to each step input with no link. This separates the two sections, shows the exact clock edge at which each falling edge takes effect, and shows that rising edges do nothing. Second, the gated controls are tried with one input at a time, with both inputs, and with all four together; pulses are applied while a control is held. This separates correct gating and priority from a simple OR of the inputs. Third, a BCD link is run across more than two wraps of the count. Fourth, a bi-quinary link is run for four full periods, and the number of high pulses in each ten-pulse window is counted. This shows whether the divider is symmetric and whether its period is correct.

// File: rtl/dcp9_pkg.sv
// Package: shared constants and types for the two-section decade counter.
// Assumes one divide-by-two bit below a divide-by-five field.
package dcp9_pkg;
    localparam int QUINT_MOD = 5;
    localparam int QUINT_W   = $clog2(QUINT_MOD);
    localparam int COUNT_W   = QUINT_W + 1;
    localparam logic [QUINT_W-1:0] QUINT_PRESET = QUINT_W'(4);
    localparam logic               BIN_PRESET   = 1'b1;

    typedef enum logic [1:0] {
        CTRL_RUN    = 2'd0,
        CTRL_CLEAR  = 2'd1,
        CTRL_PRESET = 2'd2
    } ctrl_mode_e;
endpackage

// File: rtl/dcp9_fall_detect.sv
// Module: synchronizes an asynchronous step input and emits a one-cycle
// pulse when it goes from 1 to 0. Assumes SYNC_STAGES >= 1. Registers
// clear to 0, so an input that is high at reset release gives no pulse.
module dcp9_fall_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_in,
    output logic fall_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the input through the synchronizer chain and keep the previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q[0] <= step_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // A falling edge is a 1 followed by a 0 at the end of the chain.
    always_comb fall_pulse = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/dcp9_ctrl_decode.sv
// Module: gates the clear and preset inputs (all inputs of a group must be
// high) and resolves priority. Preset is tested before clear.
module dcp9_ctrl_decode
    import dcp9_pkg::*;
#(
    parameter int GATE_N = 2
) (
    input  logic [GATE_N-1:0] clr_in,
    input  logic [GATE_N-1:0] pre_in,
    output ctrl_mode_e        mode
);
    // Select the active control; preset wins over clear.
    always_comb begin
        if (&pre_in)      mode = CTRL_PRESET;
        else if (&clr_in) mode = CTRL_CLEAR;
        else              mode = CTRL_RUN;
    end
endmodule

// File: rtl/dcp9_count_stage.sv
// Module: one counting section. It wraps at MODULUS and is loaded with
// PRESET_VAL or zero while a control is active. Assumes MODULUS >= 2.
// A modulus of 2 gives a toggle bit.
module dcp9_count_stage
    import dcp9_pkg::*;
#(
    parameter int MODULUS = 5,
    parameter int WIDTH   = (MODULUS > 2) ? $clog2(MODULUS) : 1,
    parameter logic [WIDTH-1:0] PRESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_mode_e       mode,
    input  logic             step,
    output logic [WIDTH-1:0] value_q
);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

    logic [WIDTH-1:0] next_val;

    // Choose the next value: forced value first, then a wrap or an increment.
    always_comb begin
        unique case (mode)
            CTRL_PRESET: next_val = PRESET_VAL;
            CTRL_CLEAR:  next_val = '0;
            default: begin
                if (!step)                next_val = value_q;
                else if (value_q == LAST) next_val = '0;
                else                      next_val = value_q + WIDTH'(1);
            end
        endcase
    end

    // Hold the section state.
    always_ff @(posedge clk) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= next_val;
    end
endmodule

// File: rtl/decade_counter_p9.sv
// Module: top of the two-section decade counter. It contains a divide-by-two
// section (bit 0) and a divide-by-five section (bits 3..1), each stepped by
// the falling edge of its own input. The output shows a forced value in the
// same cycle a gated control is asserted. Assumes all inputs may be
// asynchronous to clk.
module decade_counter_p9
    import dcp9_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_x2,
    input  logic               step_x5,
    input  logic               clr_a,
    input  logic               clr_b,
    input  logic               pre_a,
    input  logic               pre_b,
    output logic [COUNT_W-1:0] count_q
);
    localparam int CHANNELS = 2;

    logic [CHANNELS-1:0] step_raw;
    logic [CHANNELS-1:0] step_fall;
    ctrl_mode_e          mode;
    logic                bin_q;
    logic [QUINT_W-1:0]  quint_q;

    // Collect the step inputs: channel 0 feeds the binary section, channel 1 the quinary one.
    always_comb step_raw = {step_x5, step_x2};

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_edge
        dcp9_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_fall (
            .clk       (clk),
            .rst_n     (rst_n),
            .step_in   (step_raw[ch]),
            .fall_pulse(step_fall[ch])
        );
    end

    dcp9_ctrl_decode #(.GATE_N(2)) u_ctrl (
        .clr_in({clr_b, clr_a}),
        .pre_in({pre_b, pre_a}),
        .mode  (mode)
    );

    dcp9_count_stage #(.MODULUS(2), .WIDTH(1), .PRESET_VAL(BIN_PRESET)) u_bin (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .step   (step_fall[0]),
        .value_q(bin_q)
    );

    dcp9_count_stage #(.MODULUS(QUINT_MOD), .WIDTH(QUINT_W), .PRESET_VAL(QUINT_PRESET)) u_quint (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .step   (step_fall[1]),
        .value_q(quint_q)
    );

    // Drive the output; an active control shows its forced value at once.
    always_comb begin
        unique case (mode)
            CTRL_PRESET: count_q = {QUINT_PRESET, BIN_PRESET};
            CTRL_CLEAR:  count_q = '0;
            default:     count_q = {quint_q, bin_q};
        endcase
    end
endmodule

// File: rtl/dcp9_checker.sv
// Module: assertion checker for decade_counter_p9, attached by bind.
module dcp9_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_a,
    input logic       clr_b,
    input logic       pre_a,
    input logic       pre_b,
    input logic [3:0] count_q
);
    logic ctrl_on;
    always_comb ctrl_on = (clr_a & clr_b) | (pre_a & pre_b);

    // R5
    preset_nine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_a && pre_b) |-> count_q == 4'b1001);
    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a && clr_b && !(pre_a && pre_b)) |-> count_q == 4'b0000);
    // R3
    quint_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q[3:1] <= 3'd4);
    // R7
    release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctrl_on) && $past(rst_n)) |-> count_q == $past(count_q));
endmodule

bind decade_counter_p9 dcp9_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_a  (clr_a),
    .clr_b  (clr_b),
    .pre_a  (pre_a),
    .pre_b  (pre_b),
    .count_q(count_q)
);

// File: tb/decade_counter_p9_bench.sv
module decade_counter_p9_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv_x2 = 1'b1, drv_x5 = 1'b1;
    logic clr_a = 1'b0, clr_b = 1'b0, pre_a = 1'b0, pre_b = 1'b0;
    logic step_x2, step_x5;
    logic [3:0] count_q;
    int   link_mode = 0;   // 0 free, 1 BCD (q0 -> x5), 2 bi-quinary (q3 -> x2)
    int   checks = 0, errors = 0, cycles = 0;
    bit   started = 0;

    always #4 clk = ~clk;  // 125 MHz

    assign step_x2 = (link_mode == 2) ? count_q[3] : drv_x2;
    assign step_x5 = (link_mode == 1) ? count_q[0] : drv_x5;

    decade_counter_p9 u_decade_counter_p9 (
        .clk(clk), .rst_n(rst_n), .step_x2(step_x2), .step_x5(step_x5),
        .clr_a(clr_a), .clr_b(clr_b), .pre_a(pre_a), .pre_b(pre_b),
        .count_q(count_q)
    );

    // Behavioural reference model
    int m_lo = 0, m_hi = 0;
    bit hist_a[$];
    bit hist_b[$];

    function automatic int model_out();
        if (pre_a && pre_b) return 9;
        if (clr_a && clr_b) return 0;
        return m_hi * 2 + m_lo;
    endfunction

    always @(posedge clk) begin
        int cur;
        bit in_a, in_b, fa, fb;
        cur  = model_out();
        in_a = (link_mode == 2) ? cur[3] : drv_x2;
        in_b = (link_mode == 1) ? cur[0] : drv_x5;
        if (!rst_n) begin
            m_lo = 0; m_hi = 0;
            hist_a = '{0, 0, 0};
            hist_b = '{0, 0, 0};
            started = 1;
        end else begin
            fa = hist_a[hist_a.size()-3] && !hist_a[hist_a.size()-2];
            fb = hist_b[hist_b.size()-3] && !hist_b[hist_b.size()-2];
            if (pre_a && pre_b) begin m_lo = 1; m_hi = 4; end
            else if (clr_a && clr_b) begin m_lo = 0; m_hi = 0; end
            else begin
                if (fa) m_lo = 1 - m_lo;
                if (fb) m_hi = (m_hi + 1) % 5;
            end
            hist_a.push_back(in_a); void'(hist_a.pop_front());
            hist_b.push_back(in_b); void'(hist_b.pop_front());
        end
    end

    // Cycle-by-cycle comparison against the model (R10 timing, all functions)
    always @(negedge clk) begin
        #2;
        if (started) begin
            checks++;
            if (count_q !== 4'(model_out())) begin
                errors++;
                $display("FAIL R10 model compare at cycle %0d: actual %b expected %b",
                         cycles, count_q, 4'(model_out()));
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input bit on_x5);
        @(negedge clk);
        if (on_x5) drv_x5 = 1'b0; else drv_x2 = 1'b0;
        waitn(5);
        if (on_x5) drv_x5 = 1'b1; else drv_x2 = 1'b1;
        waitn(5);
    endtask

    task automatic switch_mode(input int m);
        @(negedge clk);
        clr_a = 1; clr_b = 1;
        waitn(1);
        link_mode = m;
        drv_x2 = 1; drv_x5 = 1;
        waitn(6);
        clr_a = 0; clr_b = 0;
        waitn(6);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int highs;
        waitn(3);
        #1 chk(count_q == 4'd0, "R11 reset value", count_q, 0);
        @(negedge clk) rst_n = 1'b1;
        waitn(4);
        #1 chk(count_q == 4'd0, "R1 no count from initial high inputs", count_q, 0);

        // R10 / R2: latency of one falling edge on step_x2
        @(negedge clk) drv_x2 = 1'b0;
        @(negedge clk);
        @(negedge clk); #1 chk(count_q == 4'd0, "R10 unchanged after second edge", count_q, 0);
        @(negedge clk); #1 chk(count_q == 4'd1, "R10 R2 changed after third edge", count_q, 1);
        @(negedge clk) drv_x2 = 1'b1;
        waitn(6); #1 chk(count_q == 4'd1, "R1 rising edge ignored", count_q, 1);
        pulse(0); #1 chk(count_q == 4'd0, "R2 second toggle", count_q, 0);

        // R3: quinary sequence with wrap
        for (int k = 1; k <= 6; k++) begin
            pulse(1);
            #1 chk(count_q[3:1] == 3'(k % 5) && count_q[0] == 1'b0, "R3 quinary step", count_q, (k % 5) * 2);
        end
        pulse(0);  // count now 3 (hi 1, lo 1)

        // R4 / R12 / R7: clear gating
        @(negedge clk) clr_a = 1'b1;
        #1 chk(count_q == 4'd3, "R4 single clear input ignored", count_q, 3);
        waitn(3); #1 chk(count_q == 4'd3, "R4 single clear held", count_q, 3);
        @(negedge clk) clr_b = 1'b1;
        #1 chk(count_q == 4'd0, "R12 R4 clear immediate", count_q, 0);
        pulse(0); pulse(1);
        #1 chk(count_q == 4'd0, "R7 no count during clear", count_q, 0);
        @(negedge clk) begin clr_a = 1'b0; clr_b = 1'b0; end
        waitn(6); #1 chk(count_q == 4'd0, "R7 lost edges stay lost", count_q, 0);

        // R5 / R6 / R7: preset gating and priority
        @(negedge clk) pre_b = 1'b1;
        #1 chk(count_q == 4'd0, "R5 single preset input ignored", count_q, 0);
        @(negedge clk) pre_a = 1'b1;
        #1 chk(count_q == 4'd9, "R5 R12 preset immediate", count_q, 9);
        @(negedge clk) begin clr_a = 1'b1; clr_b = 1'b1; end
        #1 chk(count_q == 4'd9, "R6 preset over clear", count_q, 9);
        pulse(1);
        #1 chk(count_q == 4'd9, "R7 no count during preset", count_q, 9);
        @(negedge clk) begin pre_a = 0; pre_b = 0; clr_a = 0; clr_b = 0; end
        waitn(4); #1 chk(count_q == 4'd9, "R7 nine kept after release", count_q, 9);
        pulse(1);
        #1 chk(count_q == 4'd1, "R3 wrap from nine", count_q, 1);

        // R8: BCD link
        switch_mode(1);
        for (int k = 1; k <= 25; k++) begin
            pulse(0);
            #1 chk(count_q == 4'(k % 10), "R8 BCD sequence", count_q, k % 10);
        end

        // R9: bi-quinary link
        switch_mode(2);
        highs = 0;
        for (int k = 1; k <= 40; k++) begin
            pulse(1);
            #1 chk(count_q[0] == 1'((k / 5) % 2), "R9 divide-by-ten phase", count_q[0], (k / 5) % 2);
            if (count_q[0]) highs++;
            if (k % 10 == 0) begin
                chk(highs == 5, "R9 duty per ten pulses", highs, 5);
                highs = 0;
            end
        end

        waitn(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule